// File: doc/BRIEF.md
# Non-maskable interrupt acknowledge unit

This block is the acknowledge side of a core's interrupt interface for non-maskable interrupts. It keeps a small table of interrupt sources, each with a pending bit, an active bit, a priority and a non-maskable flag. A one-cycle read strobe returns a 64-bit result on the next cycle. That result is either the ID of the selected interrupt or a reserved special ID that explains why nothing was taken. A read that returns a real ID is itself the acknowledge: in the same clock edge the source moves from pending to active.

Selection takes the pending, non-active source with the numerically lowest priority. Ties go to the lowest index. The winner is only signalled when its priority is strictly below the priority-mask input. It is only acknowledged when it also carries the non-maskable flag. The `irq` output is derived from the table itself. It therefore falls in the same cycle that the reply appears, so an unmask right after the read never sees a stale request. Source `i` carries ID `BASE_ID + i`.

A small state machine sequences the reply. `ST_IDLE` moves to `ST_REPLY` on a read strobe (transition *accept*). `ST_REPLY` stays in `ST_REPLY` on another strobe (transition *chain*) or returns to `ST_IDLE` (transition *finish*). `rd_valid` is high exactly in `ST_REPLY`.

Top module: `nmi_ack_unit`

## Requirements
- R1: A high `rd_req` in cycle N makes `rd_valid` high in cycle N+1 only. Strobes in consecutive cycles give replies in consecutive cycles.
- R2: When the winner is non-maskable and its priority is below `pmr`, the reply is `BASE_ID + index` of the winner. The winner is the pending, non-active source with the lowest priority value. The same edge sets the winner's active bit and clears its pending bit.
- R3: Among candidates of equal priority, the one with the lowest index wins.
- R4: `rd_data` bits 63 down to `ID_BITS` read as zero. `ID_BITS` is 16 or 24.
- R5: When there is no candidate, or when the winner's priority is not strictly below `pmr`, the reply is 1023 and no pending or active bit changes.
- R6: When the winner is not non-maskable, the reply is 1022. The winner stays pending and nothing is activated.
- R7: `irq` is high exactly when a read would return a real ID. After an acknowledge, `irq` already reflects the new table in the cycle the reply is valid.
- R8: After reset, all pending, active and non-maskable bits are clear and all priorities are all-ones. `rd_valid` and `irq` are low.
- R9: An active source is never selected. A high bit in `clr_act` clears that source's active bit at the next edge.
- R10: `cfg_we` writes `cfg_prio` and `cfg_nmi` into source `cfg_idx`. A high bit in `set_pend` sets that pending bit. An acknowledge of the same source in the same edge wins, leaving it not pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pmr | input | PRIO_W | Priority mask; a winner is signalled only when its priority is strictly below this value |
| set_pend | input | NUM_SRC | One bit per source; sets the pending bit |
| cfg_we | input | 1 | Writes the priority and flag of one source |
| cfg_idx | input | $clog2(NUM_SRC) | Source written by `cfg_we` |
| cfg_prio | input | PRIO_W | Priority value to write (lower is more urgent) |
| cfg_nmi | input | 1 | Non-maskable flag to write |
| clr_act | input | NUM_SRC | One bit per source; clears the active bit |
| rd_req | input | 1 | Read strobe; the read is the acknowledge |
| rd_valid | output | 1 | Reply valid, one cycle after each strobe |
| rd_data | output | 64 | Reply: ID in the low `ID_BITS` bits, zero above |
| irq | output | 1 | An acknowledgeable interrupt exists |

## Verification
On every cycle, the assertions check the following. Each strobe gets exactly one reply on the next cycle. The upper bits of the reply stay zero. A strobe taken while `irq` is high yields a real ID, and one taken while `irq` is low yields a special ID. The active set never grows by more than one source per edge. The choice of winner under priority ties, the exact special ID for an empty table, a low-priority winner or a winner without the flag, and the clear-active path are shown only by the bench's scenarios. There, a behavioural copy of the table is scanned and compared with the outputs every clock.

// File: rtl/nmi_ack_pkg.sv
package nmi_ack_pkg;
    localparam int unsigned ID_NONE   = 1023;
    localparam int unsigned ID_NOTNMI = 1022;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_REPLY = 1'b1
    } ack_state_t;
endpackage

// File: rtl/nmi_src_table.sv
module nmi_src_table #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 8,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SRC-1:0]              set_pend,
    input  logic [NUM_SRC-1:0]              clr_act,
    input  logic [NUM_SRC-1:0]              ack_vec,
    input  logic                            cfg_we,
    input  logic [IDX_W-1:0]                cfg_idx,
    input  logic [PRIO_W-1:0]               cfg_prio,
    input  logic                            cfg_nmi,
    output logic [NUM_SRC-1:0]              pend,
    output logic [NUM_SRC-1:0]              act,
    output logic [NUM_SRC-1:0]              nmi,
    output logic [NUM_SRC-1:0][PRIO_W-1:0]  prio
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[i] <= 1'b0;
                act[i]  <= 1'b0;
                nmi[i]  <= 1'b0;
                prio[i] <= '1;
            end else begin
                pend[i] <= (pend[i] | set_pend[i]) & ~ack_vec[i];
                act[i]  <= (act[i] & ~clr_act[i]) | ack_vec[i];
                if (cfg_we && cfg_idx == IDX_W'(i)) begin
                    nmi[i]  <= cfg_nmi;
                    prio[i] <= cfg_prio;
                end
            end
        end
    end
endmodule

// File: rtl/nmi_select.sv
module nmi_select #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 8,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]              cand,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio,
    output logic                            found,
    output logic [IDX_W-1:0]                win_idx,
    output logic [PRIO_W-1:0]               win_prio
);
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cand[i] && (!found || prio[i] < win_prio)) begin
                found    = 1'b1;
                win_idx  = IDX_W'(i);
                win_prio = prio[i];
            end
        end
    end
endmodule

// File: rtl/nmi_ack_unit.sv
module nmi_ack_unit
    import nmi_ack_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 8,
    parameter int ID_BITS = 24,
    parameter int BASE_ID = 32,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PRIO_W-1:0]   pmr,
    input  logic [NUM_SRC-1:0]  set_pend,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [PRIO_W-1:0]   cfg_prio,
    input  logic                cfg_nmi,
    input  logic [NUM_SRC-1:0]  clr_act,
    input  logic                rd_req,
    output logic                rd_valid,
    output logic [63:0]         rd_data,
    output logic                irq
);
    localparam logic [63:0] ID_MASK = (64'd1 << ID_BITS) - 64'd1;

    logic [NUM_SRC-1:0]             pend, act, nmi, ack_vec;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
    logic                           found, sufficient, take;
    logic [IDX_W-1:0]               win_idx;
    logic [PRIO_W-1:0]              win_prio;
    logic [63:0]                    next_id, res_q;
    ack_state_t                     state, state_n;

    nmi_src_table #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_table (
        .clk(clk), .rst_n(rst_n), .set_pend(set_pend), .clr_act(clr_act),
        .ack_vec(ack_vec), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_prio(cfg_prio), .cfg_nmi(cfg_nmi),
        .pend(pend), .act(act), .nmi(nmi), .prio(prio)
    );

    nmi_select #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_select (
        .cand(pend & ~act), .prio(prio),
        .found(found), .win_idx(win_idx), .win_prio(win_prio)
    );

    always_comb begin
        sufficient = found && (win_prio < pmr);
        take       = sufficient && nmi[win_idx];
        if (!sufficient)
            next_id = 64'(ID_NONE);
        else if (!take)
            next_id = 64'(ID_NOTNMI);
        else
            next_id = (64'(BASE_ID) + 64'(win_idx)) & ID_MASK;
        ack_vec = (rd_req && take) ? (NUM_SRC'(1) << win_idx) : '0;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (rd_req) state_n = ST_REPLY;
            ST_REPLY: state_n = rd_req ? ST_REPLY : ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            res_q <= '0;
        end else begin
            state <= state_n;
            if (rd_req) res_q <= next_id;
        end
    end

    always_comb begin
        rd_valid = (state == ST_REPLY);
        rd_data  = rd_valid ? res_q : '0;
        irq      = take;
    end
endmodule

// File: rtl/nmi_ack_unit_chk.sv
module nmi_ack_unit_chk #(
    parameter int NUM_SRC = 8,
    parameter int ID_BITS = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_req,
    input logic               rd_valid,
    input logic [63:0]        rd_data,
    input logic               irq,
    input logic [NUM_SRC-1:0] act
);
    a_r1_reply_next: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    a_r1_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data >> ID_BITS) == 64'd0);
    a_r7_real_when_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && irq) |=> (rd_valid && rd_data < 64'd1022));
    a_r5_special_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !irq) |=> (rd_data == 64'd1022 || rd_data == 64'd1023));
    a_r2_one_activation: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ($countones(act) <= $countones($past(act)) + 1));
endmodule

bind nmi_ack_unit nmi_ack_unit_chk #(.NUM_SRC(NUM_SRC), .ID_BITS(ID_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_valid(rd_valid),
    .rd_data(rd_data), .irq(irq), .act(act)
);

// File: tb/nmi_ack_unit_test.sv
`timescale 1ns/1ps
module nmi_ack_unit_test;
    localparam int N    = 8;
    localparam int PW   = 8;
    localparam int BASE = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] pmr = '0;
    logic [N-1:0]  set_pend = '0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_idx = '0;
    logic [PW-1:0] cfg_prio = '0;
    logic          cfg_nmi = 1'b0;
    logic [N-1:0]  clr_act = '0;
    logic          rd_req = 1'b0;
    logic          rd_valid;
    logic [63:0]   rd_data;
    logic          irq;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    bit m_pend[N];
    bit m_act[N];
    bit m_nmi[N];
    int m_prio[N];

    always #4 clk = ~clk;

    nmi_ack_unit #(.NUM_SRC(N), .PRIO_W(PW), .ID_BITS(24), .BASE_ID(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .pmr(pmr), .set_pend(set_pend),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_prio(cfg_prio), .cfg_nmi(cfg_nmi),
        .clr_act(clr_act), .rd_req(rd_req), .rd_valid(rd_valid),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string tag, input longint act_v, input longint exp_v);
        checks++;
        if (act_v != exp_v) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act_v, exp_v);
        end
    endtask

    // reference scan: returns 1023 / 1022 / real ID, and the winner index
    function automatic int ref_scan(output int w, output bit tk);
        int best = 1000;
        w = -1;
        tk = 0;
        for (int i = 0; i < N; i++)
            if (m_pend[i] && !m_act[i] && m_prio[i] < best) begin
                best = m_prio[i];
                w = i;
            end
        if (w < 0 || best >= int'(pmr)) return 1023;
        if (!m_nmi[w]) return 1022;
        tk = 1;
        return BASE + w;
    endfunction

    task automatic tick(input string tag);
        int w;
        bit tk;
        int exp_id;
        bit exp_v;
        int dummy_w;
        bit exp_irq;
        exp_id = ref_scan(w, tk);
        exp_v  = rd_req;
        for (int i = 0; i < N; i++) begin
            if (set_pend[i]) m_pend[i] = 1;
            if (clr_act[i]) m_act[i] = 0;
            if (rd_req && tk && i == w) begin
                m_pend[i] = 0;
                m_act[i]  = 1;
            end
        end
        if (cfg_we) begin
            m_prio[cfg_idx] = int'(cfg_prio);
            m_nmi[cfg_idx]  = cfg_nmi;
        end
        @(posedge clk);
        @(negedge clk);
        check({tag, " valid"}, rd_valid, exp_v);
        if (exp_v) check({tag, " id"}, rd_data, exp_id);
        void'(ref_scan(dummy_w, exp_irq));
        check({tag, " irq"}, irq, exp_irq);
        set_pend = '0;
        clr_act  = '0;
        cfg_we   = 1'b0;
        rd_req   = 1'b0;
    endtask

    task automatic cfg(input int idx, input int p, input bit f);
        cfg_we = 1'b1;
        cfg_idx = 3'(idx);
        cfg_prio = PW'(p);
        cfg_nmi = f;
        tick("R10 config");
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_pend[i] = 0; m_act[i] = 0; m_nmi[i] = 0; m_prio[i] = 255;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R8 reset valid", rd_valid, 0);
        check("R8 reset irq", irq, 0);
        pmr = 8'h80;

        // R5: empty table
        rd_req = 1'b1; tick("R5 empty read");
        check("R5 empty id", rd_data, 1023);
        tick("R1 idle after reply");

        // R2/R7: single non-maskable source acknowledged
        cfg(2, 8'h40, 1);
        set_pend[2] = 1'b1; tick("R10 pend src2");
        check("R7 irq before ack", irq, 1);
        rd_req = 1'b1; tick("R2 ack src2");
        check("R7 irq dropped with reply", irq, 0);
        rd_req = 1'b1; tick("R9 active excluded");

        // R6: winner lacks non-maskable flag
        cfg(5, 8'h10, 0);
        cfg(1, 8'h20, 1);
        set_pend[5] = 1'b1; set_pend[1] = 1'b1; tick("R10 pend 5 and 1");
        rd_req = 1'b1; tick("R6 non-nmi winner");
        rd_req = 1'b1; tick("R6 still pending");

        // R5: insufficient priority
        pmr = 8'h10;
        rd_req = 1'b1; tick("R5 mask equal");
        pmr = 8'h05;
        rd_req = 1'b1; tick("R5 mask below");
        pmr = 8'h80;
        cfg(5, 8'h10, 1);
        rd_req = 1'b1; tick("R2 ack src5");
        rd_req = 1'b1; tick("R2 ack src1 next");

        // R3: tie between sources 3 and 6
        cfg(3, 8'h30, 1);
        cfg(6, 8'h30, 1);
        set_pend[6] = 1'b1; set_pend[3] = 1'b1; tick("R3 pend tie");
        rd_req = 1'b1; tick("R3 tie lowest index");
        // R1: back-to-back reads
        rd_req = 1'b1; tick("R1 back to back a");
        rd_req = 1'b1; tick("R1 back to back b");
        rd_req = 1'b1; tick("R1 back to back c");

        // R9: clear active and re-acknowledge
        clr_act[2] = 1'b1; tick("R9 clear active src2");
        set_pend[2] = 1'b1; tick("R9 repend src2");
        rd_req = 1'b1; tick("R9 re-ack src2");

        // R10: same-edge set and acknowledge
        clr_act[2] = 1'b1; tick("R9 clear again");
        set_pend[2] = 1'b1; tick("R10 pend");
        rd_req = 1'b1; set_pend[2] = 1'b1; tick("R10 ack wins over set");
        rd_req = 1'b1; tick("R4 R10 after collision");
        check("R4 upper bits", rd_data >> 24, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule